// File: doc/BRIEF.md
# Display Controller Serial Command Decoder

This block is the host-side command front end of a two-plane electronic shelf label display controller. Bytes arrive over a serial port. The port runs in one of two modes: a 4-wire mode, where a separate command/data pin tags each byte, or a 3-wire mode, where a flag bit at the start of each frame does the tagging. The block decodes opcodes and stores their parameter bytes in a configuration register file, which loads fixed defaults on reset. The register file is presented to the rest of the chip on one flat bus.

Two data-start opcodes open a pixel stream into one of two planes: black/white or red. Each plane holds one bit per pixel, packed eight pixels per byte. The planes sit in a small internal frame buffer, and a combinational read port on that buffer serves the panel scan. The power-on, power-off and refresh opcodes only update a power status bit and hold the active-low busy output for a fixed count of clocks. A keyed deep-sleep opcode makes the block deaf until reset.

Top module: `epd_cmd_frontend`

## Requirements
- R1: With `bus_sel`=0 each frame is 8 bits MSB first, and `dc_in` sampled at the eighth rising `sclk` marks the byte: 0 means opcode, 1 means parameter/data. With `bus_sel`=1 each frame is 9 bits MSB first, and the first bit is that flag (0 opcode, 1 data).
- R2: While `cs_n` is high the bit counter is cleared, so a partial frame is discarded and the next frame decodes correctly.
- R3: On reset, `cfg_regs` byte k (bits 8k+7..8k) takes these values. Byte 0 holds opcode 00h, default 0Fh. Bytes 1..5 hold opcode 01h, defaults 03h,00h,26h,26h,03h. Byte 6 holds opcode 03h, default 00h. Bytes 7..9 hold opcode 06h, defaults 17h each. Byte 10 holds opcode 30h, default 3Ch. Byte 11 holds opcode 50h, default 00h. Byte 12 holds opcode 41h, default 00h. Bytes 13..15 hold opcode 42h, defaults 00h. After reset `busy_n`=1, `powered`=0 and `asleep`=0.
- R4: Data bytes after an opcode fill that opcode's bytes in order, starting at its lowest byte. Bytes beyond the opcode's count, and data after an opcode that has no stored parameters, change nothing.
- R5: Opcode 07h followed by a first data byte equal to A5h sets `asleep`. Any other value leaves it clear. Once `asleep` is set, every byte is ignored until reset.
- R6: Opcode 10h (plane 0, black/white) or 13h (plane 1, red) sets the write address to 0. Each following data byte is stored at the current address of that plane, and the address then advances by one.
- R7: A data byte that arrives when the address has reached `FB_BYTES` = H_PIXELS*V_LINES/8 is discarded. The address does not wrap, and byte 0 keeps its value.
- R8: Opcode 11h, or any other opcode, closes the pixel stream. Later data bytes are not written to either plane.
- R9: Opcodes 04h, 02h and 12h drive `busy_n` low for exactly `BUSY_CYCLES` clocks. Opcode 04h sets `powered`, opcode 02h clears it, and opcode 12h leaves it unchanged.
- R10: A byte that completes while `busy_n` is low is ignored, whether it is an opcode or a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Serial mode: 0 = 4-wire, 1 = 3-wire |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial bit clock, sampled on its rising edge |
| sdin | input | 1 | Serial data, MSB first |
| dc_in | input | 1 | Command/data tag in 4-wire mode |
| busy_n | output | 1 | Low while a power or refresh timer runs |
| powered | output | 1 | Power status bit |
| asleep | output | 1 | Deep sleep status bit |
| cfg_regs | output | 128 | Configuration bytes, byte k at bits 8k+7..8k |
| rd_plane | input | 1 | Frame buffer read plane (0 black/white, 1 red) |
| rd_addr | input | ADDR_W (7) | Frame buffer read byte address |
| rd_data | output | 8 | Frame buffer read data |

## Verification
The bench pushes 130 bytes into a 128-byte plane. A design that wraps the address would overwrite byte 0, and one that ignores the limit would write outside the plane. It sends an opcode and a parameter while the busy timer runs, so a decoder that does not gate input on busy would change the panel register. It sends a partial frame before a full one, where a stale bit counter would misalign every later byte. It feeds deep sleep a wrong key before the right one, then tries to write a register and start power, which catches both a loose key check and a sleep state that still listens.

// File: rtl/epd_cmd_pkg.sv
package epd_cmd_pkg;
  localparam int NREG = 16;

  localparam logic [7:0] OP_PANEL   = 8'h00;
  localparam logic [7:0] OP_PWR     = 8'h01;
  localparam logic [7:0] OP_POFF    = 8'h02;
  localparam logic [7:0] OP_PSEQ    = 8'h03;
  localparam logic [7:0] OP_PON     = 8'h04;
  localparam logic [7:0] OP_BOOST   = 8'h06;
  localparam logic [7:0] OP_SLEEP   = 8'h07;
  localparam logic [7:0] OP_BW      = 8'h10;
  localparam logic [7:0] OP_STOP    = 8'h11;
  localparam logic [7:0] OP_REFRESH = 8'h12;
  localparam logic [7:0] OP_RED     = 8'h13;
  localparam logic [7:0] OP_CLK     = 8'h30;
  localparam logic [7:0] OP_TSEL    = 8'h41;
  localparam logic [7:0] OP_TWR     = 8'h42;
  localparam logic [7:0] OP_VCOM    = 8'h50;
  localparam logic [7:0] SLEEP_KEY  = 8'hA5;

  typedef struct packed {
    logic       ok;
    logic [3:0] idx;
  } slot_t;

  // Reset value of configuration byte i.
  function automatic logic [7:0] reg_default(input int i);
    case (i)
      0:       return 8'h0F;
      1, 5:    return 8'h03;
      3, 4:    return 8'h26;
      7, 8, 9: return 8'h17;
      10:      return 8'h3C;
      default: return 8'h00;
    endcase
  endfunction

  // Where parameter byte n of opcode op lands, if anywhere.
  function automatic slot_t param_slot(input logic [7:0] op, input logic [3:0] n);
    logic [3:0] base;
    logic [3:0] cnt;
    slot_t      s;
    base = 4'd0;
    cnt  = 4'd0;
    case (op)
      OP_PANEL: begin base = 4'd0;  cnt = 4'd1; end
      OP_PWR:   begin base = 4'd1;  cnt = 4'd5; end
      OP_PSEQ:  begin base = 4'd6;  cnt = 4'd1; end
      OP_BOOST: begin base = 4'd7;  cnt = 4'd3; end
      OP_CLK:   begin base = 4'd10; cnt = 4'd1; end
      OP_VCOM:  begin base = 4'd11; cnt = 4'd1; end
      OP_TSEL:  begin base = 4'd12; cnt = 4'd1; end
      OP_TWR:   begin base = 4'd13; cnt = 4'd3; end
      default:  begin base = 4'd0;  cnt = 4'd0; end
    endcase
    s.ok  = (n < cnt);
    s.idx = base + n;
    return s;
  endfunction
endpackage

// File: rtl/epd_serial_rx.sv
module epd_serial_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       three_wire,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdin,
  input  logic       dc_in,
  output logic       rx_valid,
  output logic       rx_is_data,
  output logic [7:0] rx_byte
);
  logic [2:0] sclk_q;
  logic [1:0] cs_q, sd_q, dc_q;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [3:0] last_bit;
  logic       sclk_rise, cs_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      sd_q   <= '0;
      dc_q   <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      sd_q   <= {sd_q[0], sdin};
      dc_q   <= {dc_q[0], dc_in};
    end
  end

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign cs_idle   = cs_q[1];
  assign last_bit  = three_wire ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      rx_valid   <= 1'b0;
      rx_is_data <= 1'b0;
      rx_byte    <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_idle) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[6:0], sd_q[1]};
        if (bit_cnt == last_bit) begin
          rx_valid   <= 1'b1;
          rx_byte    <= {shreg[6:0], sd_q[1]};
          rx_is_data <= three_wire ? shreg[7] : dc_q[1];
          bit_cnt    <= '0;
        end else begin
          bit_cnt <= bit_cnt + 4'd1;
        end
      end
    end
  end

  assert_cs_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (bit_cnt == 4'd0 && !rx_valid));
  assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);
endmodule

// File: rtl/epd_fb_mem.sv
module epd_fb_mem #(
  parameter int FB_BYTES = 128,
  parameter int ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wr_plane,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_plane,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] rd_pl [2];

  for (genvar p = 0; p < 2; p++) begin : g_plane
    logic [7:0] mem [FB_BYTES];
    always_ff @(posedge clk) begin
      if (we && (wr_plane == 1'(p)) && (32'(wr_addr) < FB_BYTES))
        mem[wr_addr] <= wr_data;
    end
    assign rd_pl[p] = (32'(rd_addr) < FB_BYTES) ? mem[rd_addr] : 8'h00;
  end

  assign rd_data = rd_pl[rd_plane];
endmodule

// File: rtl/epd_cmd_decode.sv
module epd_cmd_decode
  import epd_cmd_pkg::*;
#(
  parameter int FB_BYTES    = 128,
  parameter int ADDR_W      = 7,
  parameter int BUSY_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_is_data,
  input  logic [7:0]        rx_byte,
  output logic [NREG*8-1:0] cfg_regs,
  output logic              busy_n,
  output logic              powered,
  output logic              asleep,
  output logic              fb_we,
  output logic              fb_plane,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [7:0]        fb_wdata
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(FB_BYTES);

  logic [7:0]       regs [NREG];
  logic [7:0]       cur_op;
  logic [3:0]       pcnt;
  logic             streaming;
  logic [ADDR_W:0]  wptr;
  logic [CNT_W-1:0] busy_cnt;

  // Named events used by the logic and the assertions.
  logic  accept, cmd_evt, dat_evt, starts_busy, reg_wr, sleep_req;
  slot_t slot;

  assign busy_n      = (busy_cnt == '0);
  assign accept      = rx_valid && !asleep && busy_n;
  assign cmd_evt     = accept && !rx_is_data;
  assign dat_evt     = accept && rx_is_data;
  assign starts_busy = cmd_evt && (rx_byte == OP_PON || rx_byte == OP_POFF ||
                                   rx_byte == OP_REFRESH);
  assign slot        = param_slot(cur_op, pcnt);
  assign reg_wr      = dat_evt && !streaming && slot.ok;
  assign sleep_req   = dat_evt && !streaming && cur_op == OP_SLEEP &&
                       pcnt == 4'd0 && rx_byte == SLEEP_KEY;
  assign fb_we       = dat_evt && streaming && (wptr < LIMIT);
  assign fb_addr     = wptr[ADDR_W-1:0];
  assign fb_wdata    = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_default(i);
      cur_op    <= 8'hFF;
      pcnt      <= '0;
      streaming <= 1'b0;
      fb_plane  <= 1'b0;
      wptr      <= '0;
      busy_cnt  <= '0;
      powered   <= 1'b0;
      asleep    <= 1'b0;
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (cmd_evt) begin
        cur_op    <= rx_byte;
        pcnt      <= '0;
        streaming <= (rx_byte == OP_BW) || (rx_byte == OP_RED);
        if (rx_byte == OP_BW || rx_byte == OP_RED) begin
          wptr     <= '0;
          fb_plane <= (rx_byte == OP_RED);
        end
        if (starts_busy) busy_cnt <= CNT_W'(BUSY_CYCLES);
        if (rx_byte == OP_PON)  powered <= 1'b1;
        if (rx_byte == OP_POFF) powered <= 1'b0;
      end
      if (dat_evt) begin
        if (fb_we) wptr <= wptr + 1'b1;
        if (pcnt != 4'hF) pcnt <= pcnt + 4'd1;
      end
      if (reg_wr)    regs[slot.idx] <= rx_byte;
      if (sleep_req) asleep <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) cfg_regs[i*8 +: 8] = regs[i];
  end

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |=> wptr == $past(wptr) + 1'b1);
  assert_addr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= LIMIT);
  assert_sleep_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> asleep);
  assert_sleep_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !reg_wr && !fb_we && !starts_busy);
  assert_busy_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) |=> busy_cnt == $past(busy_cnt) - 1'b1);
  assert_busy_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !fb_we && !reg_wr && !sleep_req);
endmodule

// File: rtl/epd_cmd_frontend.sv
module epd_cmd_frontend
  import epd_cmd_pkg::*;
#(
  parameter int H_PIXELS    = 64,
  parameter int V_LINES     = 16,
  parameter int BUSY_CYCLES = 200,
  localparam int FB_BYTES   = H_PIXELS * V_LINES / 8,
  localparam int ADDR_W     = $clog2(FB_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              dc_in,
  output logic              busy_n,
  output logic              powered,
  output logic              asleep,
  output logic [NREG*8-1:0] cfg_regs,
  input  logic              rd_plane,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic              rx_valid, rx_is_data;
  logic [7:0]        rx_byte;
  logic              fb_we, fb_plane;
  logic [ADDR_W-1:0] fb_addr;
  logic [7:0]        fb_wdata;

  epd_serial_rx u_rx (
    .clk(clk), .rst_n(rst_n), .three_wire(bus_sel), .cs_n(cs_n),
    .sclk(sclk), .sdin(sdin), .dc_in(dc_in),
    .rx_valid(rx_valid), .rx_is_data(rx_is_data), .rx_byte(rx_byte)
  );

  epd_cmd_decode #(
    .FB_BYTES(FB_BYTES), .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_is_data(rx_is_data),
    .rx_byte(rx_byte), .cfg_regs(cfg_regs), .busy_n(busy_n),
    .powered(powered), .asleep(asleep), .fb_we(fb_we), .fb_plane(fb_plane),
    .fb_addr(fb_addr), .fb_wdata(fb_wdata)
  );

  epd_fb_mem #(.FB_BYTES(FB_BYTES), .ADDR_W(ADDR_W)) u_fb (
    .clk(clk), .we(fb_we), .wr_plane(fb_plane), .wr_addr(fb_addr),
    .wr_data(fb_wdata), .rd_plane(rd_plane), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );
endmodule

// File: tb/test_epd_cmd_frontend.sv
module test_epd_cmd_frontend;
  localparam int BUSY = 200;
  localparam int FBB  = 64 * 16 / 8;

  logic clk = 0, rst_n = 0, bus_sel = 1, cs_n = 1, sclk = 0, sdin = 0, dc_in = 0;
  logic rd_plane = 0;
  logic [6:0] rd_addr = '0;
  logic busy_n, powered, asleep;
  logic [127:0] cfg_regs;
  logic [7:0] rd_data;

  int errors = 0, checks = 0, busy_len = 0;
  logic [7:0] exp_reg [16];

  always #4 clk = ~clk;

  epd_cmd_frontend #(.H_PIXELS(64), .V_LINES(16), .BUSY_CYCLES(BUSY)) i_epd_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .cs_n(cs_n), .sclk(sclk),
    .sdin(sdin), .dc_in(dc_in), .busy_n(busy_n), .powered(powered),
    .asleep(asleep), .cfg_regs(cfg_regs), .rd_plane(rd_plane),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) if (rst_n && !busy_n) busy_len++;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic v);
    sdin = v; tick(2); sclk = 1; tick(2); sclk = 0;
  endtask

  task automatic send_byte(logic flag, logic [7:0] b);
    cs_n = 0; dc_in = flag; tick(2);
    if (bus_sel) shift_bit(flag);
    for (int i = 7; i >= 0; i--) shift_bit(b[i]);
    tick(2); cs_n = 1; tick(6);
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < 16; i++) check_eq(req, cfg_regs[i*8 +: 8], exp_reg[i]);
  endtask

  task automatic check_mem(string req, logic pl, int addr, int exp);
    rd_plane = pl; rd_addr = 7'(addr); #1;
    check_eq(req, rd_data, exp);
  endtask

  task automatic load_defaults();
    exp_reg = '{8'h0F, 8'h03, 8'h00, 8'h26, 8'h26, 8'h03, 8'h00, 8'h17,
                8'h17, 8'h17, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  endtask

  task automatic t_reset();
    load_defaults();
    check_regs("R3 defaults");
    check_eq("R3 busy_n", busy_n, 1);
    check_eq("R3 powered", powered, 0);
    check_eq("R3 asleep", asleep, 0);
  endtask

  task automatic t_four_wire();
    bus_sel = 0;
    send_byte(0, 8'h01); send_byte(1, 8'hAA); send_byte(1, 8'hBB);
    exp_reg[1] = 8'hAA; exp_reg[2] = 8'hBB;
    check_regs("R1 4-wire power setting");
    bus_sel = 1;
  endtask

  task automatic t_three_wire();
    send_byte(0, 8'h06);
    send_byte(1, 8'h11); send_byte(1, 8'h22); send_byte(1, 8'h33); send_byte(1, 8'h44);
    exp_reg[7] = 8'h11; exp_reg[8] = 8'h22; exp_reg[9] = 8'h33;
    check_regs("R1 R4 3-wire booster, extra byte dropped");
  endtask

  task automatic t_no_param();
    send_byte(0, 8'h05); send_byte(1, 8'h99);
    check_regs("R4 opcode without parameters");
    send_byte(0, 8'h42);
    send_byte(1, 8'h01); send_byte(1, 8'h02); send_byte(1, 8'h03); send_byte(1, 8'h04);
    exp_reg[13] = 8'h01; exp_reg[14] = 8'h02; exp_reg[15] = 8'h03;
    check_regs("R4 sensor write order");
  endtask

  task automatic t_fragment();
    cs_n = 0; tick(2);
    for (int i = 0; i < 5; i++) shift_bit(1'b1);
    tick(2); cs_n = 1; tick(6);
    send_byte(0, 8'h00); send_byte(1, 8'h5A);
    exp_reg[0] = 8'h5A;
    check_regs("R2 partial frame discarded");
  endtask

  task automatic t_fill_stop();
    send_byte(0, 8'h10);
    for (int i = 0; i < FBB + 2; i++) send_byte(1, 8'(i + 7));
    for (int a = 0; a < FBB; a++) check_mem("R6 R7 black/white fill", 0, a, (a + 7) & 8'hFF);
  endtask

  task automatic t_red();
    send_byte(0, 8'h13);
    for (int i = 0; i < 4; i++) send_byte(1, 8'(8'hC0 + i));
    for (int a = 0; a < 4; a++) check_mem("R6 red plane", 1, a, 8'hC0 + a);
    for (int a = 0; a < 4; a++) check_mem("R6 red leaves black/white", 0, a, a + 7);
  endtask

  task automatic t_stop();
    send_byte(0, 8'h10);
    for (int i = 0; i < 3; i++) send_byte(1, 8'(8'hA0 + i));
    send_byte(0, 8'h11); send_byte(1, 8'hEE);
    for (int a = 0; a < 3; a++) check_mem("R8 stream before stop", 0, a, 8'hA0 + a);
    check_mem("R8 data after stop", 0, 3, 8'h0A);
    send_byte(0, 8'h10); send_byte(1, 8'hB1);
    send_byte(0, 8'h50); send_byte(1, 8'h66);
    exp_reg[11] = 8'h66;
    check_mem("R8 other opcode closes stream", 0, 1, 8'hA1);
    check_regs("R8 parameter after stream");
  endtask

  task automatic t_busy();
    busy_len = 0; send_byte(0, 8'h04); tick(BUSY + 50);
    check_eq("R9 power-on busy length", busy_len, BUSY);
    check_eq("R9 powered after 04h", powered, 1);
    busy_len = 0; send_byte(0, 8'h12); tick(BUSY + 50);
    check_eq("R9 refresh busy length", busy_len, BUSY);
    check_eq("R9 refresh keeps power", powered, 1);
    busy_len = 0; send_byte(0, 8'h02); tick(BUSY + 50);
    check_eq("R9 power-off busy length", busy_len, BUSY);
    check_eq("R9 powered after 02h", powered, 0);
  endtask

  task automatic t_busy_ignore();
    send_byte(0, 8'h04);
    check_eq("R9 busy asserted", busy_n, 0);
    send_byte(0, 8'h00); send_byte(1, 8'h33);
    tick(BUSY);
    check_eq("R10 busy released", busy_n, 1);
    check_regs("R10 bytes during busy ignored");
    send_byte(0, 8'h00); send_byte(1, 8'h33);
    exp_reg[0] = 8'h33;
    check_regs("R10 accepted after busy");
  endtask

  task automatic t_sleep();
    send_byte(0, 8'h07); send_byte(1, 8'h12);
    check_eq("R5 wrong key", asleep, 0);
    send_byte(0, 8'h07); send_byte(1, 8'hA5);
    check_eq("R5 key accepted", asleep, 1);
    send_byte(0, 8'h00); send_byte(1, 8'h77);
    check_regs("R5 register write while asleep");
    busy_len = 0; send_byte(0, 8'h02); tick(20);
    check_eq("R5 no busy while asleep", busy_len, 0);
    check_eq("R5 power unchanged while asleep", powered, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    tick(5); rst_n = 1; tick(5);
    t_reset();
    t_four_wire();
    t_three_wire();
    t_no_param();
    t_fragment();
    t_fill_stop();
    t_red();
    t_stop();
    t_busy();
    t_busy_ignore();
    t_sleep();
    rst_n = 0; tick(3);
    load_defaults();
    check_regs("R3 defaults after second reset");
    check_eq("R3 asleep cleared by reset", asleep, 0);
    check_eq("R3 powered cleared by reset", powered, 0);
    rst_n = 1; tick(3);
    summary();
    $finish;
  end
endmodule